// File: doc/BRIEF.md
# Bus cycle ready generator

This block produces the active-low ready indication that tells a processor its current bus cycle may finish. Two ready sources feed it: one that already meets setup and hold against the system clock and is sampled directly, and one that may change at any time and first passes through a falling-edge synchronizer. Each source has its own active-low enable, normally driven by an address decoder, so only the source that belongs to the addressed device can end the cycle. If both the synchronized asynchronous pair and the synchronous pair are active, the outcome is the same, and an inactive synchronous pair cannot end a ready that the asynchronous pair holds.

All sampling happens on the falling edge of the system clock. The synchronous pair and the synchronizer output are used only when the peripheral clock phase input is high. A low on either status line releases the ready line so that each new bus cycle starts as not-ready. The output is an open-drain drive enable: when `rdy_drive_low` is high the shared ready line is pulled low, and otherwise an external pull-up holds it high. The block also holds the synchronizer that turns the active-low reset request into the active-high system reset, and that reset forces ready active.

Top module: `bus_ready_gen`

## Requirements
- R1: At a falling clock edge where both status lines are high, the phase input is high, and both `srdy_n` and `srdy_en_n` are low, `rdy_drive_low` is 1 after that edge.
- R2: At a falling clock edge where both status lines are high and the phase input is low, `rdy_drive_low` keeps its value; the ready inputs have no effect there.
- R3: The asynchronous pair counts as active only when both `ardy_n` and `ardy_en_n` have been low for two consecutive falling edges (two synchronizer stages). With the phase input high and status lines high, ready is driven from the third falling edge after the pair goes low, and released at the third falling edge after it goes inactive.
- R4: While the synchronized asynchronous pair is active and the phase input is high, an inactive synchronous pair does not release ready.
- R5: At a falling clock edge where `stat0_n` or `stat1_n` is low and system reset is inactive, `rdy_drive_low` is 0 after that edge.
- R6: Once `rdy_drive_low` rises, it stays 1 for at least one more falling edge unless a status line is low; after that, it falls at the first edge with the phase input high and no ready pair active.
- R7: `rdy_drive_low` is 1 at the falling edge after one where `sys_reset` is 1.
- R8: `sys_reset` follows the inverse of `rst_in_n` through two falling-edge stages. A change just after a falling edge appears at the output two edges later. A change just before an edge appears one edge later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all state updates on its falling edge |
| rst_in_n | input | 1 | Asynchronous active-low reset request |
| stat0_n | input | 1 | Active-low status line 0 |
| stat1_n | input | 1 | Active-low status line 1 |
| pclk_ph | input | 1 | Peripheral clock phase; sampling is allowed when high |
| srdy_n | input | 1 | Synchronous ready, active low |
| srdy_en_n | input | 1 | Enable for synchronous ready, active low |
| ardy_n | input | 1 | Asynchronous ready, active low |
| ardy_en_n | input | 1 | Enable for asynchronous ready, active low |
| sys_reset | output | 1 | Synchronized active-high system reset |
| rdy_drive_low | output | 1 | Open-drain enable; 1 pulls the shared ready line low |

## Verification
The assertions assume that the status lines, the phase input and the synchronous pair are stable around each falling edge. Only the asynchronous pair and the reset request may change freely. The bench changes every input five nanoseconds after a falling edge, well clear of the next one, so each value is sampled on a known edge. The checker stays idle until the reset synchronizer has shown a high output once, because the design has no power-on state before then. Every property that is not about reset excludes cycles where reset is active.

// File: rtl/bus_ready_gen.sv
module bus_ready_gen #(
  parameter int ASYNC_STAGES = 2,
  parameter int RST_STAGES   = 2
) (
  input  logic clk,
  input  logic rst_in_n,
  input  logic stat0_n,
  input  logic stat1_n,
  input  logic pclk_ph,
  input  logic srdy_n,
  input  logic srdy_en_n,
  input  logic ardy_n,
  input  logic ardy_en_n,
  output logic sys_reset,
  output logic rdy_drive_low
);
  localparam int AMSB = ASYNC_STAGES - 1;
  localparam int RMSB = RST_STAGES - 1;

  logic [RMSB:0] rst_pipe;
  logic [AMSB:0] ardy_pipe, aen_pipe;
  logic          hold_q;

  always_ff @(negedge clk) begin
    rst_pipe  <= {rst_pipe[RMSB-1:0], ~rst_in_n};
    ardy_pipe <= {ardy_pipe[AMSB-1:0], ~ardy_n};
    aen_pipe  <= {aen_pipe[AMSB-1:0], ~ardy_en_n};
  end

  assign sys_reset = rst_pipe[RMSB];

  wire async_hit   = ardy_pipe[AMSB] & aen_pipe[AMSB];
  wire sync_hit    = ~srdy_n & ~srdy_en_n;
  wire cycle_start = ~stat0_n | ~stat1_n;

  always_ff @(negedge clk) begin
    if (sys_reset) begin
      rdy_drive_low <= 1'b1;
      hold_q        <= 1'b0;
    end else if (cycle_start) begin
      rdy_drive_low <= 1'b0;
      hold_q        <= 1'b0;
    end else if (pclk_ph && (async_hit || sync_hit)) begin
      rdy_drive_low <= 1'b1;
      hold_q        <= ~rdy_drive_low;
    end else begin
      if (pclk_ph && !hold_q) rdy_drive_low <= 1'b0;
      hold_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bus_ready_gen_chk.sv
module bus_ready_gen_chk (
  input logic clk,
  input logic rst_in_n,
  input logic stat0_n,
  input logic stat1_n,
  input logic pclk_ph,
  input logic srdy_n,
  input logic srdy_en_n,
  input logic sys_reset,
  input logic rdy_drive_low
);
  logic armed = 1'b0;
  always_ff @(negedge clk) if (sys_reset === 1'b1) armed <= 1'b1;

  AST_SYNC_SET: assert property (@(negedge clk) disable iff (!armed)
    (!sys_reset && stat0_n && stat1_n && pclk_ph && !srdy_n && !srdy_en_n) |=> rdy_drive_low); // R1
  AST_PHASE_GATE: assert property (@(negedge clk) disable iff (!armed)
    (!sys_reset && stat0_n && stat1_n && !pclk_ph) |=> $stable(rdy_drive_low)); // R2
  AST_STATUS_FLOAT: assert property (@(negedge clk) disable iff (!armed)
    (!sys_reset && (!stat0_n || !stat1_n)) |=> !rdy_drive_low); // R5
  AST_MIN_HOLD: assert property (@(negedge clk) disable iff (!armed)
    ($rose(rdy_drive_low) && stat0_n && stat1_n && !sys_reset) |=> rdy_drive_low); // R6
  AST_RESET_FORCE: assert property (@(negedge clk) disable iff (!armed)
    sys_reset |=> rdy_drive_low); // R7
  AST_RESET_SYNC: assert property (@(negedge clk) disable iff (!armed)
    (!rst_in_n && $past(!rst_in_n)) |=> sys_reset); // R8
endmodule

bind bus_ready_gen bus_ready_gen_chk u_chk (
  .clk(clk), .rst_in_n(rst_in_n), .stat0_n(stat0_n), .stat1_n(stat1_n),
  .pclk_ph(pclk_ph), .srdy_n(srdy_n), .srdy_en_n(srdy_en_n),
  .sys_reset(sys_reset), .rdy_drive_low(rdy_drive_low)
);

// File: tb/bus_ready_gen_test.sv
`timescale 1ns/1ps
module bus_ready_gen_test;
  logic clk = 1'b0;
  logic rst_in_n = 1'b0;
  logic stat0_n = 1'b1, stat1_n = 1'b1, pclk_ph = 1'b0;
  logic srdy_n = 1'b1, srdy_en_n = 1'b1, ardy_n = 1'b1, ardy_en_n = 1'b1;
  logic sys_reset, rdy_drive_low;
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  bus_ready_gen uut (
    .clk(clk), .rst_in_n(rst_in_n), .stat0_n(stat0_n), .stat1_n(stat1_n),
    .pclk_ph(pclk_ph), .srdy_n(srdy_n), .srdy_en_n(srdy_en_n),
    .ardy_n(ardy_n), .ardy_en_n(ardy_en_n),
    .sys_reset(sys_reset), .rdy_drive_low(rdy_drive_low)
  );

  // shared ready line with pull-up: low when driven, high otherwise
  wire rdy_line = rdy_drive_low ? 1'b0 : 1'b1;

  // {stat0_n, stat1_n, pclk_ph, srdy_n, srdy_en_n, ardy_n, ardy_en_n, expected drive}
  localparam logic [7:0] VEC [15] = '{
    8'b0011111_0, // R5 status low floats
    8'b1100011_0, // R2 phase low, no sample
    8'b1111011_0, // R1 enable only
    8'b1110111_0, // R1 ready only
    8'b1110011_1, // R1 both low
    8'b1101111_1, // R6 held
    8'b1111111_0, // R6 released
    8'b1010011_0, // R5 status1 low blocks
    8'b1110011_1, // R1
    8'b1111111_1, // R6 minimum two cycles
    8'b1111111_0, // R6
    8'b1110011_1, // R1
    8'b0100011_0, // R5 status0 low overrides
    8'b1110011_1, // R1
    8'b1110011_1  // R1 stays while active
  };

  task automatic step();
    @(negedge clk);
    #5;
  endtask

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive_in(logic [6:0] v);
    {stat0_n, stat1_n, pclk_ph, srdy_n, srdy_en_n, ardy_n, ardy_en_n} = v;
  endtask

  initial begin
    #2_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (3) step();
    check("R7 reset state sys_reset", sys_reset, 1'b1);
    check("R7 reset state ready line", rdy_line, 1'b0);
    rst_in_n = 1'b1;
    drive_in(7'b1101111);
    step(); check("R8 release first edge", sys_reset, 1'b1);
    step(); check("R8 release second edge", sys_reset, 1'b0);
    step(); check("R2 ready held after reset", rdy_drive_low, 1'b1);

    foreach (VEC[i]) begin
      drive_in(VEC[i][7:1]);
      step();
      check($sformatf("R1/R2/R5/R6 vector %0d", i), rdy_drive_low, VEC[i][0]);
    end

    drive_in(7'b0011111); step(); check("R5 float", rdy_drive_low, 1'b0);
    drive_in(7'b1111100);
    step(); check("R3 sync stage 1", rdy_drive_low, 1'b0);
    step(); check("R3 sync stage 2", rdy_drive_low, 1'b0);
    step(); check("R3 async asserts", rdy_drive_low, 1'b1);
    step(); check("R6 hold", rdy_drive_low, 1'b1);
    step(); check("R4 sync inactive ignored", rdy_drive_low, 1'b1);
    drive_in(7'b0011100); step(); check("R5 float over async", rdy_drive_low, 1'b0);
    drive_in(7'b1101100); step(); check("R3 phase low gates async", rdy_drive_low, 1'b0);
    drive_in(7'b1111100); step(); check("R3 phase high uses async", rdy_drive_low, 1'b1);
    drive_in(7'b1101100); step(); check("R6 held on phase low", rdy_drive_low, 1'b1);
    drive_in(7'b1111110);
    step(); check("R3 deassert edge 1", rdy_drive_low, 1'b1);
    step(); check("R3 deassert edge 2", rdy_drive_low, 1'b1);
    step(); check("R3 deassert edge 3", rdy_drive_low, 1'b0);

    drive_in(7'b0011111);
    rst_in_n = 1'b0;
    step(); check("R8 assert edge 1", sys_reset, 1'b0);
    step(); check("R8 assert edge 2", sys_reset, 1'b1);
    check("R7 not yet forced", rdy_drive_low, 1'b0);
    step(); check("R7 forced one clock after", rdy_drive_low, 1'b1);
    rst_in_n = 1'b1;
    drive_in(7'b1101111);
    step(); check("R8 deassert edge 1", sys_reset, 1'b1);
    step(); check("R8 deassert edge 2", sys_reset, 1'b0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule